// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked host and an external asynchronous static RAM of 65,536 words by 24 bits. The host hands over one word access at a time through a valid/ready request channel: a 16-bit word address, a write flag, 24 bits of write data and a vector-mode flag. The controller turns each request into a pin sequence on the memory: address lines, a pair of chip selects (one active low, one active high), output enable, write enable, an upper-address source select and a separate upper-address vector pin. Every pin leaves a register, and the width of each phase is a whole number of clock cycles set by parameters.

The memory can take bit 15 of the address from two places. In vector mode the select pin is high and the vector pin carries bit 15. In normal mode the select pin is low and bit 15 travels on address line 15. Both modes reach the same word. The data bus is split into an output, an output enable and an input, and these are joined into one tristate bus at the chip pad. The controller does not turn its driver on while the memory might still be driving the bus.

The request channel accepts a request on any rising clock edge where `req_valid` and `req_ready` are both high. While `req_ready` is low, the host must hold its request. Request fields are ignored from acceptance until `req_ready` rises again. Read results return on a one-cycle `rsp_valid` pulse, and that channel has no back-pressure.

Top module: `sramc_top`

## Requirements
- R1: While reset is held, and whenever idle, `req_ready` is 1, `mem_ce_n`=1, `mem_ce`=0, `mem_oe_n`=1, `mem_we_n`=1 and `mem_dq_oe`=0.
- R2: `mem_oe_n` and `mem_we_n` are low only while the memory is selected (`mem_ce_n`=0 and `mem_ce`=1), and never both at once.
- R3: During an access with `req_vec`=1: `mem_vsel`=1, `mem_xy`=address bit 15 and `mem_addr[15]`=0. With `req_vec`=0: `mem_vsel`=0, `mem_xy`=0 and `mem_addr[15]`=address bit 15. In both modes `mem_addr[14:0]` equals address bits 14..0.
- R4: A read holds `mem_oe_n` low for exactly READ_CYC cycles with `mem_we_n` high. It then pulses `rsp_valid` for one cycle, READ_CYC+1 cycles after the accepting edge, carrying the word last written to that address.
- R5: A write holds `mem_we_n` low for exactly TURN_CYC+WR_PULSE_CYC consecutive cycles, and `mem_oe_n` stays high throughout.
- R6: `mem_dq_oe` rises only after `mem_we_n` has been low for TURN_CYC cycles. It stays high for WR_PULSE_CYC+1 cycles, so it covers the cycle in which `mem_we_n` returns high.
- R7: `mem_dq_oe` is never high while `mem_oe_n` is low, nor in the cycle right after it. The host and the memory never drive the bus together.
- R8: `req_ready` is low from the cycle after acceptance until the access and its gap end. Request fields that change while busy do not alter the pins of the running access.
- R9: After a read, the memory is deselected for at least TURN_CYC cycles before the controller takes the next request.
- R10: A word written in one address mode reads back unchanged in the other mode at the same 16-bit address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, can accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 24 | Write data |
| req_vec | input | 1 | Route address bit 15 via vector pin |
| rsp_valid | output | 1 | Read data valid, one-cycle pulse |
| rsp_data | output | 24 | Read data |
| mem_addr | output | 16 | Memory address lines |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_ce | output | 1 | Chip select, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_vsel | output | 1 | Upper-bit source select (1 = vector pin) |
| mem_xy | output | 1 | Vector pin carrying address bit 15 |
| mem_dq_o | output | 24 | Data toward memory |
| mem_dq_oe | output | 1 | Pad driver enable for `mem_dq_o` |
| mem_dq_i | input | 24 | Data from the memory pad |

## Verification
Two events can fall in one cycle: the end of a read's output-enable window and the start of a following write's driver. Any slip in the gap logic would let both drivers fight over the bus. The bench provokes this with back-to-back read-then-write pairs, in directed order and in a long random mix. A bus model drives the data input only while it is selected, output-enabled and not write-enabled. The model counts every cycle in which the controller's driver is also on, and that count must stay at zero. The pairing of mode switching with readback is judged by writing in one address mode and reading in the other.

// File: rtl/sramc_pkg.sv
package sramc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD   = 3'd1,
    ST_RGAP = 3'd2,
    ST_WZ   = 3'd3,
    ST_WD   = 3'd4,
    ST_WH   = 3'd5
  } st_e;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 24;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
    logic              wr;
    logic              vec;
  } req_t;
endpackage

// File: rtl/sramc_seq.sv
module sramc_seq
  import sramc_pkg::*;
#(
  parameter int READ_CYC     = 2,
  parameter int WR_PULSE_CYC = 1,
  parameter int TURN_CYC     = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  output logic req_ready,
  output logic accept,
  output st_e  st_nxt,
  output logic rd_last
);
  localparam int MAXC = (READ_CYC > WR_PULSE_CYC) ?
                        ((READ_CYC > TURN_CYC) ? READ_CYC : TURN_CYC) :
                        ((WR_PULSE_CYC > TURN_CYC) ? WR_PULSE_CYC : TURN_CYC);
  localparam int CW = (MAXC < 2) ? 1 : $clog2(MAXC);
  localparam logic [CW-1:0] RD_END = CW'(READ_CYC - 1);
  localparam logic [CW-1:0] WP_END = CW'(WR_PULSE_CYC - 1);
  localparam logic [CW-1:0] TN_END = CW'(TURN_CYC - 1);

  st_e st;
  logic [CW-1:0] cnt, cnt_nxt;

  assign req_ready = (st == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign rd_last   = (st == ST_RD) && (cnt == RD_END);

  always_comb begin
    st_nxt  = st;
    cnt_nxt = cnt + 1'b1;
    case (st)
      ST_IDLE: begin
        cnt_nxt = '0;
        if (accept) st_nxt = req_write ? ST_WZ : ST_RD;
      end
      ST_RD:   if (cnt == RD_END) begin st_nxt = ST_RGAP; cnt_nxt = '0; end
      ST_RGAP: if (cnt == TN_END) begin st_nxt = ST_IDLE; cnt_nxt = '0; end
      ST_WZ:   if (cnt == TN_END) begin st_nxt = ST_WD;   cnt_nxt = '0; end
      ST_WD:   if (cnt == WP_END) begin st_nxt = ST_WH;   cnt_nxt = '0; end
      ST_WH:   begin st_nxt = ST_IDLE; cnt_nxt = '0; end
      default: begin st_nxt = ST_IDLE; cnt_nxt = '0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      st  <= st_nxt;
      cnt <= cnt_nxt;
    end
  end

  // R8
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
endmodule

// File: rtl/sramc_pins.sv
module sramc_pins
  import sramc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  req_t              req,
  input  st_e               st_nxt,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_ce,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_vsel,
  output logic              mem_xy,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe
);
  localparam int LOW_W = ADDR_W - 1;

  req_t lat, cur;
  logic sel_nxt, oe_nxt, we_nxt, drv_nxt;

  assign cur     = accept ? req : lat;
  assign sel_nxt = (st_nxt != ST_IDLE) && (st_nxt != ST_RGAP);
  assign oe_nxt  = (st_nxt == ST_RD);
  assign we_nxt  = (st_nxt == ST_WZ) || (st_nxt == ST_WD);
  assign drv_nxt = (st_nxt == ST_WD) || (st_nxt == ST_WH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat       <= '0;
      mem_addr  <= '0;
      mem_ce_n  <= 1'b1;
      mem_ce    <= 1'b0;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_vsel  <= 1'b0;
      mem_xy    <= 1'b0;
      mem_dq_o  <= '0;
      mem_dq_oe <= 1'b0;
    end else begin
      if (accept) lat <= req;
      mem_addr  <= {cur.vec ? 1'b0 : cur.addr[ADDR_W-1], cur.addr[LOW_W-1:0]};
      mem_vsel  <= cur.vec;
      mem_xy    <= cur.vec & cur.addr[ADDR_W-1];
      mem_ce_n  <= !sel_nxt;
      mem_ce    <= sel_nxt;
      mem_oe_n  <= !oe_nxt;
      mem_we_n  <= !we_nxt;
      mem_dq_o  <= cur.wdata;
      mem_dq_oe <= drv_nxt;
    end
  end

  // R2
  strobe_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || !mem_we_n) |-> (!mem_ce_n && mem_ce));
  // R2
  oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));
  // R7
  drv_vs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);
  // R7
  turn_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!mem_oe_n) |-> !mem_dq_oe);
  // R6
  drv_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (!mem_we_n && $past(!mem_we_n)));
  // R6
  drv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_dq_oe) |-> $past(mem_we_n));
  // R9
  read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> mem_ce_n);
endmodule

// File: rtl/sramc_rdcap.sv
module sramc_rdcap
  import sramc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_last,
  input  logic [DATA_W-1:0] dq_i,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_last;
      if (rd_last) rsp_data <= dq_i;
    end
  end

  // R4
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/sramc_top.sv
module sramc_top
  import sramc_pkg::*;
#(
  parameter int READ_CYC     = 2,
  parameter int WR_PULSE_CYC = 1,
  parameter int TURN_CYC     = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [15:0] req_addr,
  input  logic [23:0] req_wdata,
  input  logic        req_vec,
  output logic        rsp_valid,
  output logic [23:0] rsp_data,
  output logic [15:0] mem_addr,
  output logic        mem_ce_n,
  output logic        mem_ce,
  output logic        mem_oe_n,
  output logic        mem_we_n,
  output logic        mem_vsel,
  output logic        mem_xy,
  output logic [23:0] mem_dq_o,
  output logic        mem_dq_oe,
  input  logic [23:0] mem_dq_i
);
  logic accept, rd_last;
  st_e  st_nxt;
  req_t req;

  assign req = '{addr: req_addr, wdata: req_wdata, wr: req_write, vec: req_vec};

  sramc_seq #(
    .READ_CYC(READ_CYC), .WR_PULSE_CYC(WR_PULSE_CYC), .TURN_CYC(TURN_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_ready(req_ready), .accept(accept), .st_nxt(st_nxt), .rd_last(rd_last)
  );

  sramc_pins u_pins (
    .clk(clk), .rst_n(rst_n), .accept(accept), .req(req), .st_nxt(st_nxt),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_ce(mem_ce),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_vsel(mem_vsel),
    .mem_xy(mem_xy), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe)
  );

  sramc_rdcap u_cap (
    .clk(clk), .rst_n(rst_n), .rd_last(rd_last), .dq_i(mem_dq_i),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );
endmodule

// File: tb/sim_sramc_top.sv
`timescale 1ns/1ps
module sim_sramc_top;
  localparam int RC = 2, WP = 1, TC = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_vec = 1'b0;
  logic [15:0] req_addr = '0;
  logic [23:0] req_wdata = '0;
  logic req_ready, rsp_valid, mem_ce_n, mem_ce, mem_oe_n, mem_we_n;
  logic mem_vsel, mem_xy, mem_dq_oe;
  logic [23:0] rsp_data, mem_dq_o, mem_dq_i;
  logic [15:0] mem_addr;

  int nchk = 0, nerr = 0, conflicts = 0;
  logic [23:0] model [logic [15:0]];
  logic [23:0] expm  [logic [15:0]];
  logic [15:0] pool [16];

  always #5 clk = ~clk;

  sramc_top #(.READ_CYC(RC), .WR_PULSE_CYC(WP), .TURN_CYC(TC)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_vec(req_vec), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_ce(mem_ce),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_vsel(mem_vsel),
    .mem_xy(mem_xy), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i)
  );

  // memory model: word picked by select and vector pin
  wire        m_sel   = !mem_ce_n && mem_ce;
  wire [15:0] m_ea    = {mem_vsel ? mem_xy : mem_addr[15], mem_addr[14:0]};
  wire        m_drive = m_sel && !mem_oe_n && mem_we_n;

  always @* begin
    if (m_drive) mem_dq_i = model.exists(m_ea) ? model[m_ea] : 24'h0;
    else         mem_dq_i = 24'hxxxxxx;
  end
  always @(posedge mem_we_n) if (m_sel) model[m_ea] = mem_dq_oe ? mem_dq_o : 24'hxxxxxx;
  always @(negedge clk) if (rst_n && mem_dq_oe && m_drive) conflicts++;

  function automatic logic [23:0] exp_word(input logic [15:0] a);
    return expm.exists(a) ? expm[a] : 24'h0;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exv);
    end
  endtask

  task automatic access(input bit wr, input logic [15:0] a, input logic [23:0] d, input bit vec);
    int idx = 0, we_cnt = 0, oe_cnt = 0, drv_cnt = 0, drv_at = -1, gap = 0, lat = -1;
    bit route_ok = 1, strobe_ok = 1, rdy_first = 0;
    logic [23:0] got = '0;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_vec = vec;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    rdy_first = req_ready;
    req_valid = 0; req_addr = ~a; req_wdata = ~d; req_vec = ~vec; req_write = ~wr;
    while (!req_ready) begin
      idx++;
      if (m_sel) begin
        if (mem_vsel !== vec || mem_addr[14:0] !== a[14:0]) route_ok = 0;
        if (vec  && (mem_xy !== a[15] || mem_addr[15] !== 1'b0)) route_ok = 0;
        if (!vec && (mem_xy !== 1'b0 || mem_addr[15] !== a[15])) route_ok = 0;
      end else begin
        gap++;
        if (!mem_oe_n || !mem_we_n) strobe_ok = 0;
      end
      if (mem_dq_oe && drv_at < 0) drv_at = we_cnt;
      if (mem_dq_oe) drv_cnt++;
      if (!mem_we_n) we_cnt++;
      if (!mem_oe_n) oe_cnt++;
      if (rsp_valid) begin lat = idx; got = rsp_data; end
      @(negedge clk);
    end
    chk(rdy_first == 0, "R8 ready low after accept", 32'(rdy_first), 0);
    chk(route_ok, "R3/R8 upper-bit routing and held address", 32'(mem_addr), 32'(a));
    chk(strobe_ok, "R2 strobe while deselected", 0, 1);
    if (wr) begin
      expm[a] = d;
      chk(we_cnt == TC + WP, "R5 write-enable width", we_cnt, TC + WP);
      chk(oe_cnt == 0, "R5 output enable during write", oe_cnt, 0);
      chk(drv_at == TC, "R6 driver start", drv_at, TC);
      chk(drv_cnt == WP + 1, "R6 driver length", drv_cnt, WP + 1);
    end else begin
      chk(oe_cnt == RC, "R4 output-enable width", oe_cnt, RC);
      chk(we_cnt == 0, "R4 write enable during read", we_cnt, 0);
      chk(lat == RC + 1, "R4 response latency", lat, RC + 1);
      chk(got === exp_word(a), "R4/R10 read data", got, exp_word(a));
      chk(gap >= TC, "R9 gap after read", gap, TC);
    end
  endtask

  initial begin
    #2_000_000;
    nerr++; nchk++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    void'($urandom(32'd5171));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready && mem_ce_n && !mem_ce && mem_oe_n && mem_we_n && !mem_dq_oe,
        "R1 reset pins", {mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dq_oe, req_ready}, 6'b101101);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && mem_ce_n && !mem_ce && mem_oe_n && mem_we_n && !mem_dq_oe,
        "R1 idle pins", {mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dq_oe, req_ready}, 6'b101101);
    // directed corners, R10 cross-mode
    access(1, 16'h0000, 24'h123456, 0);
    access(1, 16'hFFFF, 24'hABCDEF, 1);
    access(1, 16'h8000, 24'h800001, 1);
    access(1, 16'h7FFF, 24'h7FFF7F, 0);
    access(0, 16'hFFFF, 0, 0);   // R10 written in vector mode, read normal
    access(0, 16'h8000, 0, 0);
    access(0, 16'h0000, 0, 1);   // R10 written normal, read vector
    access(0, 16'h7FFF, 0, 1);
    // R7 read directly followed by write, same address
    access(0, 16'hFFFF, 0, 1);
    access(1, 16'hFFFF, 24'h5A5A5A, 0);
    access(0, 16'hFFFF, 0, 1);
    // random mix
    pool[0] = 16'h0000; pool[1] = 16'hFFFF; pool[2] = 16'h8000; pool[3] = 16'h7FFF;
    for (int i = 4; i < 16; i++) pool[i] = 16'($urandom);
    for (int i = 0; i < 16; i++) access(1, pool[i], 24'($urandom), 1'($urandom));
    for (int i = 0; i < 300; i++)
      access(1'($urandom), pool[$urandom % 16], 24'($urandom), 1'($urandom));
    // R7 bus conflicts
    chk(conflicts == 0, "R7 bus conflict cycles", conflicts, 0);
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule